// File: doc/BRIEF.md
# Gated Auto-Reload Timer

An up-counting timer with a configurable counter width (eight bits by default). When the counter steps past its all-ones value, it reloads a programmed preset. In the same cycle it raises a one-cycle overflow pulse. That pulse serves as an interrupt request. It can also be routed out as the shift clock of a serial shift register. A toggle output inverts on every overflow, which gives a square wave with twice the overflow period.

The count clock is either a prescaled copy of the system clock or an external clock pin. The prescaler divides by 1, 2, 4 or 8. The external pin is synchronised, and each rising edge counts once. A hardware gate input, also synchronised, can be enabled to hold the counter while the gate is low.

Software programs the block through a simple write port with three addresses: reload value, control and command. A start command copies the reload value into the counter and begins counting.

Top module: `reload_timer`

## Requirements
- R1: After reset `cnt_o` is 0, `ovf_o`, `tog_o` and `shift_clk_o` are 0, and the timer is stopped.
- R2: A write to address 2 with data bit 0 = 1 loads the reload value (address 0) into the counter, clears the prescaler and starts the timer. A write to address 2 with bit 0 = 0 stops it, and the counter then holds its value.
- R3: With the internal source selected (control bit 2 = 0), the counter advances once every 2^p clock cycles, where p is control bits [1:0]. The first step after a start comes exactly 2^p cycles after the start write.
- R4: On a step from all-ones the counter takes the reload value, and `ovf_o` is high for exactly that one cycle, when `cnt_o` first shows the reload value. With reload value r, overflows recur every (256 - r) * 2^p cycles.
- R5: `tog_o` inverts on every overflow and is otherwise stable.
- R6: With control bit 3 = 1, the counter advances only while `gate_i` is high; `gate_i` passes a two-stage synchroniser. A gate held high for G cycles yields exactly G count steps at p = 0, and a low gate freezes the counter.
- R7: With control bit 2 = 1, each rising edge of `ext_clk_i` advances the counter by one, given high and low phases of at least 4 clock cycles each. The internal prescaler then has no effect.
- R8: `shift_clk_o` repeats the overflow pulse when control bit 4 = 1 and stays 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 reload, 1 control, 2 command |
| wr_data_i | input | CNT_W | Write data |
| ext_clk_i | input | 1 | External count clock |
| gate_i | input | 1 | Count gate, high enables |
| cnt_o | output | CNT_W | Current counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| tog_o | output | 1 | Toggles on each overflow |
| shift_clk_o | output | 1 | Overflow pulse routed as shift clock |

## Verification
The hardest case to reach is the exact phase between the start write, the prescaler and the first overflow. An off-by-one in the prescaler clear, or in the registered flag, shows up only as a period one cycle short or long. The bench sweeps every prescaler setting against reload values from 0x00 to 0xFF. For each pair it measures both the first and the second overflow interval against (256 - r) * 2^p. At reload 0xFF and p = 0 the flag must stay high continuously. The gate and external-clock cases are driven from the bench clock edge, so the two-stage synchroniser latency yields an exact, predictable step count.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int PSEL_W = 2;

  typedef struct packed {
    logic              route;
    logic              gate_en;
    logic              ext_sel;
    logic [PSEL_W-1:0] psel;
  } ctrl_t;

  typedef enum logic [1:0] {
    ADDR_RELOAD = 2'd0,
    ADDR_CTRL   = 2'd1,
    ADDR_CMD    = 2'd2
  } addr_e;
endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale #(
  parameter int PSEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (PSEL_W'(i) < psel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  assign tick_o = ((pre_q & mask) == mask);

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i != '0 && tick_o && !clear_i) |=> (!tick_o || psel_i != $past(psel_i))); // R3
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             tog_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      tog_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= reload_i;
      ovf_q <= 1'b0;
    end else if (step_i) begin
      if (cnt_q == '1) begin
        cnt_q <= reload_i;
        ovf_q <= 1'b1;
        tog_q <= ~tog_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= 1'b0;
      end
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign tog_o = tog_q;

  AST_OVF_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> cnt_q == $past(reload_i)); // R4
  AST_TOG_ON_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> tog_q != $past(tog_q)); // R5
  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(tog_q)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import gtmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             ext_clk_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             tog_o,
  output logic             shift_clk_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             run_q, ext_d_q;
  logic             wr_cmd, load, ext_s, ext_rise, gate_s, pre_tick, src_tick, step, ovf;

  assign wr_cmd = wr_en_i && (wr_addr_i == ADDR_CMD);
  assign load   = wr_cmd && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      ctrl_q   <= '0;
      run_q    <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == ADDR_RELOAD) reload_q <= wr_data_i;
      if (wr_en_i && wr_addr_i == ADDR_CTRL)   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_cmd)                              run_q    <= wr_data_i[0];
    end
  end

  gtmr_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_clk_i), .q_o(ext_s));

  gtmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_i), .q_o(gate_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_d_q <= 1'b0;
    else         ext_d_q <= ext_s;
  end

  assign ext_rise = ext_s & ~ext_d_q;

  gtmr_prescale #(.PSEL_W(PSEL_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load), .psel_i(ctrl_q.psel), .tick_o(pre_tick));

  assign src_tick = ctrl_q.ext_sel ? ext_rise : pre_tick;
  assign step     = run_q & ~load & src_tick & (~ctrl_q.gate_en | gate_s);

  gtmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step), .reload_i(reload_q),
    .cnt_o(cnt_o), .ovf_o(ovf), .tog_o(tog_o));

  assign ovf_o       = ovf;
  assign shift_clk_o = ovf & ctrl_q.route;

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> cnt_o == $past(reload_q)); // R2
  AST_GATE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.gate_en && !gate_s && !load) |=> $stable(cnt_o)); // R6
  AST_EXT_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise); // R7
  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !load) |=> $stable(cnt_o)); // R2
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       ext_clk_i = 1'b0;
  logic       gate_i = 1'b0;
  logic [7:0] cnt_o;
  logic       ovf_o, tog_o, shift_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reload_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ext_clk_i(ext_clk_i), .gate_i(gate_i),
    .cnt_o(cnt_o), .ovf_o(ovf_o), .tog_o(tog_o), .shift_clk_o(shift_clk_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_ovf(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ovf_o && cyc < 5000);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c1, c2, per, snap, ovf_cnt;
    logic t0;
    logic [7:0] rl_list [5] = '{8'h00, 8'h80, 8'hF0, 8'hFD, 8'hFF};

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(cnt_o == 8'h00, "R1 cnt", cnt_o, 0);
    chk(!ovf_o && !tog_o && !shift_clk_o, "R1 flags", {ovf_o, tog_o, shift_clk_o}, 0);
    repeat (10) @(negedge clk);
    chk(cnt_o == 8'h00, "R1 stopped", cnt_o, 0);

    // R3 R4 R5 R8: sweep prescale and reload
    for (int i = 0; i < 5; i++) begin
      for (int p = 0; p < 4; p++) begin
        logic route;
        route = p[0];
        per = (256 - int'(rl_list[i])) << p;
        wr(2'd1, {3'b000, route, 2'b00, p[1:0]});
        wr(2'd0, rl_list[i]);
        t0 = tog_o;
        wr(2'd2, 8'h01);
        chk(cnt_o == rl_list[i], "R2 start load", cnt_o, rl_list[i]);
        wait_ovf(c1);
        chk(c1 == per, "R3 first period", c1, per);
        chk(cnt_o == rl_list[i], "R4 reload on ovf", cnt_o, rl_list[i]);
        chk(tog_o == ~t0, "R5 toggle", tog_o, ~t0);
        chk(shift_clk_o == route, "R8 shift clock", shift_clk_o, route);
        wait_ovf(c2);
        chk(c2 == per, "R4 period", c2, per);
        chk(tog_o == t0, "R5 toggle back", tog_o, t0);
        wr(2'd2, 8'h00);
      end
    end

    // R2: stop freezes counter
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'h00);
    snap = cnt_o;
    repeat (40) @(negedge clk);
    chk(cnt_o == snap, "R2 stop hold", cnt_o, snap);

    // R6: gate
    gate_i = 1'b0;
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h01);
    repeat (20) @(negedge clk);
    chk(cnt_o == 8'h10, "R6 gate low holds", cnt_o, 16);
    gate_i = 1'b1;
    repeat (30) @(negedge clk);
    gate_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(cnt_o == 8'h2E, "R6 gated steps", cnt_o, 46);
    repeat (20) @(negedge clk);
    chk(cnt_o == 8'h2E, "R6 gate low again", cnt_o, 46);
    wr(2'd2, 8'h00);

    // R7: external clock
    wr(2'd1, 8'h04);
    wr(2'd0, 8'hFC);
    wr(2'd2, 8'h01);
    t0 = tog_o;
    repeat (20) @(negedge clk);
    chk(cnt_o == 8'hFC, "R7 no internal count", cnt_o, 252);
    for (int k = 1; k <= 4; k++) begin
      ovf_cnt = 0;
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        ext_clk_i = (j < 4);
        if (ovf_o) ovf_cnt++;
      end
      repeat (2) @(negedge clk) if (ovf_o) ovf_cnt++;
      if (k < 4) begin
        chk(cnt_o == 8'(252 + k), "R7 ext step", cnt_o, 252 + k);
        chk(ovf_cnt == 0, "R7 no ovf", ovf_cnt, 0);
      end else begin
        chk(cnt_o == 8'hFC, "R7 ext reload", cnt_o, 252);
        chk(ovf_cnt == 1, "R4 single pulse", ovf_cnt, 1);
        chk(tog_o == ~t0, "R5 ext toggle", tog_o, ~t0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule